// File: doc/BRIEF.md
# Segment Table Address Translator

This block maps a 14-bit virtual address onto a 16-bit physical address through a four-entry segment table held in registers. The two most significant address bits pick an entry and the remaining twelve bits form an offset into it. Each entry carries a base, a length and three permission bits. A request that passes both the length check and the permission check returns the entry base plus the offset. A request that fails either check returns a fault with a cause code and no address.

Software loads the table through a one-entry-per-cycle write port. An entry whose length is zero has no memory behind it, so every reference to it faults and a handler can allocate and clear storage on first touch. A segment that allows reads but not writes traps every store to it, so a copy-on-write handler can duplicate the segment before the store is retried. Translation is combinational from the request inputs. The result is captured in a register and presented for exactly one cycle, qualified by a valid flag.

Top module: `seg_xlate_top`

## Requirements
- R1: The selector is vaddr[13:12] and the offset is vaddr[11:0]. A request that passes its checks returns paddr = base of the selected entry + zero-extended offset, truncated to 16 bits, so the sum wraps modulo 2^16.
- R2: An offset greater than or equal to the entry length produces a fault with cause 2'b01 (bounds). A fault drives the physical address to zero.
- R3: An entry of length zero faults with cause 2'b01 on every offset and every access type.
- R4: The access codes are 2'b00 read, 2'b01 write and 2'b10 fetch. The permission bits are perm[0] read, perm[1] write and perm[2] fetch. An in-range access whose permission bit is clear faults with cause 2'b10 (permission).
- R5: In a segment with perm = 3'b001 or 3'b101, a write traps with cause 2'b10 while a read at the same address translates normally.
- R6: When a request fails both checks, the bounds cause 2'b01 is reported rather than the permission cause.
- R7: The access code 2'b11 is allowed by no permission bit, so an in-range request with that code faults with cause 2'b10.
- R8: A request sampled with req_valid high at a rising edge is answered with rsp_valid high during the following cycle only. After an edge with no request, rsp_valid, rsp_fault, rsp_cause and rsp_paddr are all zero.
- R9: A table write sampled at a rising edge affects only requests sampled at later edges. A request sampled at the same edge uses the previous contents of the entry.
- R10: After reset, rsp_valid is low and every entry has base 0, length 0 and permissions 0, so every request faults with cause 2'b01.
- R11: rsp_fault is high exactly when rsp_cause is nonzero. The cause code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 14 | Virtual address: selector in the top 2 bits, offset below |
| req_acc | input | 2 | Access type: 00 read, 01 write, 10 fetch, 11 reserved |
| cfg_we | input | 1 | Table entry write enable |
| cfg_idx | input | 2 | Index of the entry to write |
| cfg_base | input | 16 | Physical base written into the entry |
| cfg_len | input | 13 | Segment length in bytes, 0 to 4096 |
| cfg_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 fetch |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_paddr | output | 16 | Translated physical address, zero on a fault |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | Fault cause: 00 none, 01 bounds, 10 permission |

## Verification
The table is loaded with segments of different bases, lengths and permission sets. Offsets are then applied at zero, at length minus one, at exactly the length and at the 4095 limit of a full-size segment, which separates an off-by-one bounds compare from a correct one. Each access type is tried against segments that allow it and segments that refuse it, and a request that breaks both rules shows which cause takes priority. A base near the top of the physical range exposes the wrap of the sum. A table write issued on the same edge as a request, followed by back-to-back requests, shows whether the response uses the old or the new entry and whether the output register clears between requests.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_kind_e;

   typedef enum logic [1:0] {
      FLT_NONE   = 2'b00,
      FLT_BOUNDS = 2'b01,
      FLT_PERM   = 2'b10,
      FLT_UNUSED = 2'b11
   } fault_kind_e;

   localparam int PERM_W  = 3;
   localparam int PERM_RD = 0;
   localparam int PERM_WR = 1;
   localparam int PERM_FX = 2;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
   parameter int NSEG   = 4,
   parameter int IDX_W  = 2,
   parameter int BASE_W = 16,
   parameter int LEN_W  = 13,
   parameter int PERM_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [BASE_W-1:0] wr_base,
   input  logic [LEN_W-1:0]  wr_len,
   input  logic [PERM_W-1:0] wr_perm,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [BASE_W-1:0] rd_base,
   output logic [LEN_W-1:0]  rd_len,
   output logic [PERM_W-1:0] rd_perm
);

   generate
      if (NSEG != (1 << IDX_W)) begin : g_bad_depth
         $error("seg_table: NSEG must equal 2**IDX_W");
      end
   endgenerate

   logic [NSEG-1:0][BASE_W-1:0] base_all;
   logic [NSEG-1:0][LEN_W-1:0]  len_all;
   logic [NSEG-1:0][PERM_W-1:0] perm_all;

   for (genvar g = 0; g < NSEG; g++) begin : g_ent
      logic [BASE_W-1:0] ent_base_q;
      logic [LEN_W-1:0]  ent_len_q;
      logic [PERM_W-1:0] ent_perm_q;
      logic              hit;

      assign hit = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_base_q <= '0;
            ent_len_q  <= '0;
            ent_perm_q <= '0;
         end else if (hit) begin
            ent_base_q <= wr_base;
            ent_len_q  <= wr_len;
            ent_perm_q <= wr_perm;
         end
      end

      assign base_all[g] = ent_base_q;
      assign len_all[g]  = ent_len_q;
      assign perm_all[g] = ent_perm_q;
   end

   assign rd_base = base_all[rd_idx];
   assign rd_len  = len_all[rd_idx];
   assign rd_perm = perm_all[rd_idx];

endmodule

// File: rtl/seg_check.sv
module seg_check
   import seg_xlate_pkg::*;
#(
   parameter int OFF_W  = 12,
   parameter int LEN_W  = 13,
   parameter int BASE_W = 16
) (
   input  logic [BASE_W-1:0] ent_base,
   input  logic [LEN_W-1:0]  ent_len,
   input  logic [PERM_W-1:0] ent_perm,
   input  logic [OFF_W-1:0]  offset,
   input  logic [1:0]        acc,
   output logic [BASE_W-1:0] paddr,
   output logic [1:0]        cause
);

   generate
      if (LEN_W < OFF_W + 1) begin : g_bad_len
         $error("seg_check: LEN_W must hold a full-size segment length");
      end
      if (BASE_W < OFF_W) begin : g_bad_base
         $error("seg_check: BASE_W must be at least OFF_W");
      end
   endgenerate

   logic              in_range;
   logic              perm_ok;
   logic [BASE_W-1:0] sum;

   assign in_range = LEN_W'(offset) < ent_len;
   assign sum      = ent_base + BASE_W'(offset);

   always_comb begin
      unique case (acc)
         ACC_READ:  perm_ok = ent_perm[PERM_RD];
         ACC_WRITE: perm_ok = ent_perm[PERM_WR];
         ACC_FETCH: perm_ok = ent_perm[PERM_FX];
         default:   perm_ok = 1'b0;
      endcase
   end

   always_comb begin
      if (!in_range) begin
         cause = FLT_BOUNDS;
      end else if (!perm_ok) begin
         cause = FLT_PERM;
      end else begin
         cause = FLT_NONE;
      end
      paddr = (cause == FLT_NONE) ? sum : '0;
   end

endmodule

// File: rtl/seg_rsp_reg.sv
module seg_rsp_reg #(
   parameter int PA_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [PA_W-1:0] in_paddr,
   input  logic [1:0]      in_cause,
   output logic            out_valid,
   output logic [PA_W-1:0] out_paddr,
   output logic            out_fault,
   output logic [1:0]      out_cause
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_paddr <= '0;
         out_fault <= 1'b0;
         out_cause <= 2'b00;
      end else if (in_valid) begin
         out_valid <= 1'b1;
         out_paddr <= in_paddr;
         out_fault <= |in_cause;
         out_cause <= in_cause;
      end else begin
         out_valid <= 1'b0;
         out_paddr <= '0;
         out_fault <= 1'b0;
         out_cause <= 2'b00;
      end
   end

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
   import seg_xlate_pkg::*;
#(
   parameter int VA_W     = 14,
   parameter int SEG_BITS = 2,
   parameter int PA_W     = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [VA_W-1:0]            req_vaddr,
   input  logic [1:0]                 req_acc,
   input  logic                       cfg_we,
   input  logic [SEG_BITS-1:0]        cfg_idx,
   input  logic [PA_W-1:0]            cfg_base,
   input  logic [VA_W-SEG_BITS:0]     cfg_len,
   input  logic [PERM_W-1:0]          cfg_perm,
   output logic                       rsp_valid,
   output logic [PA_W-1:0]            rsp_paddr,
   output logic                       rsp_fault,
   output logic [1:0]                 rsp_cause
);

   localparam int NSEG  = 1 << SEG_BITS;
   localparam int OFF_W = VA_W - SEG_BITS;
   localparam int LEN_W = OFF_W + 1;

   generate
      if (SEG_BITS < 1 || SEG_BITS >= VA_W) begin : g_bad_split
         $error("seg_xlate_top: SEG_BITS must leave a nonempty offset");
      end
   endgenerate

   logic [SEG_BITS-1:0] sel;
   logic [OFF_W-1:0]    off;
   logic [PA_W-1:0]     tbl_base;
   logic [LEN_W-1:0]    tbl_len;
   logic [PERM_W-1:0]   tbl_perm;
   logic [PA_W-1:0]     xl_paddr;
   logic [1:0]          xl_cause;

   assign sel = req_vaddr[VA_W-1 -: SEG_BITS];
   assign off = req_vaddr[OFF_W-1:0];

   seg_table #(
      .NSEG   (NSEG),
      .IDX_W  (SEG_BITS),
      .BASE_W (PA_W),
      .LEN_W  (LEN_W),
      .PERM_W (PERM_W)
   ) table_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_idx  (cfg_idx),
      .wr_base (cfg_base),
      .wr_len  (cfg_len),
      .wr_perm (cfg_perm),
      .rd_idx  (sel),
      .rd_base (tbl_base),
      .rd_len  (tbl_len),
      .rd_perm (tbl_perm)
   );

   seg_check #(
      .OFF_W  (OFF_W),
      .LEN_W  (LEN_W),
      .BASE_W (PA_W)
   ) check_i (
      .ent_base (tbl_base),
      .ent_len  (tbl_len),
      .ent_perm (tbl_perm),
      .offset   (off),
      .acc      (req_acc),
      .paddr    (xl_paddr),
      .cause    (xl_cause)
   );

   seg_rsp_reg #(
      .PA_W (PA_W)
   ) rsp_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (req_valid),
      .in_paddr  (xl_paddr),
      .in_cause  (xl_cause),
      .out_valid (rsp_valid),
      .out_paddr (rsp_paddr),
      .out_fault (rsp_fault),
      .out_cause (rsp_cause)
   );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int PA_W  = 16,
   parameter int LEN_W = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [1:0]       req_acc,
   input logic [LEN_W-1:0] sel_len,
   input logic             rsp_valid,
   input logic [PA_W-1:0]  rsp_paddr,
   input logic             rsp_fault,
   input logic [1:0]       rsp_cause
);

   p_valid_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_fault && rsp_cause == 2'b00 && rsp_paddr == '0));

   p_empty_seg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && sel_len == '0) |=> (rsp_fault && rsp_cause == 2'b01));

   p_rsvd_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_acc == 2'b11) |=> rsp_fault);

   p_fault_zero_pa_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> rsp_paddr == '0);

   p_no_cause3_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_cause != 2'b11);

endmodule

bind seg_xlate_top seg_xlate_chk #(
   .PA_W  (PA_W),
   .LEN_W (LEN_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_acc   (req_acc),
   .sel_len   (tbl_len),
   .rsp_valid (rsp_valid),
   .rsp_paddr (rsp_paddr),
   .rsp_fault (rsp_fault),
   .rsp_cause (rsp_cause)
);

// File: tb/seg_xlate_top_tb_top.sv
module seg_xlate_top_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [13:0] req_vaddr = '0;
   logic [1:0]  req_acc = 2'b00;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_idx = '0;
   logic [15:0] cfg_base = '0;
   logic [12:0] cfg_len = '0;
   logic [2:0]  cfg_perm = '0;
   logic        rsp_valid;
   logic [15:0] rsp_paddr;
   logic        rsp_fault;
   logic [1:0]  rsp_cause;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seg_xlate_top dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_vaddr (req_vaddr),
      .req_acc   (req_acc),
      .cfg_we    (cfg_we),
      .cfg_idx   (cfg_idx),
      .cfg_base  (cfg_base),
      .cfg_len   (cfg_len),
      .cfg_perm  (cfg_perm),
      .rsp_valid (rsp_valid),
      .rsp_paddr (rsp_paddr),
      .rsp_fault (rsp_fault),
      .rsp_cause (rsp_cause)
   );

   task automatic chk(input string tag, input logic ev, input logic ef,
                      input logic [1:0] ec, input logic [15:0] ep);
      n_chk++;
      if (rsp_valid !== ev || rsp_fault !== ef || rsp_cause !== ec || rsp_paddr !== ep) begin
         n_err++;
         $display("FAIL %s: got v=%0b f=%0b c=%0d pa=%h, expected v=%0b f=%0b c=%0d pa=%h",
                  tag, rsp_valid, rsp_fault, rsp_cause, rsp_paddr, ev, ef, ec, ep);
      end
   endtask

   task automatic load(input logic [1:0] idx, input logic [15:0] base,
                       input logic [12:0] len, input logic [2:0] perm);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = idx; cfg_base = base; cfg_len = len; cfg_perm = perm;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic xlate(input string tag, input logic [13:0] va, input logic [1:0] acc,
                        input logic ef, input logic [1:0] ec, input logic [15:0] ep);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_acc = acc;
      @(negedge clk);
      req_valid = 1'b0;
      chk(tag, 1'b1, ef, ec, ep);
   endtask

   task automatic t_reset;
      chk("R10 idle after reset", 1'b0, 1'b0, 2'd0, 16'h0000);
      for (int s = 0; s < 4; s++) begin
         xlate("R10 R3 cleared entry faults", {s[1:0], 12'h000}, 2'b00, 1'b1, 2'd1, 16'h0000);
      end
   endtask

   task automatic t_setup;
      load(2'd0, 16'h4000, 13'h0700, 3'b101);
      load(2'd1, 16'h0000, 13'h0500, 3'b011);
      load(2'd2, 16'h9000, 13'h0000, 3'b111);
      load(2'd3, 16'h2000, 13'h1000, 3'b011);
   endtask

   task automatic t_basic;
      xlate("R1 fetch code seg", 14'h0240, 2'b10, 1'b0, 2'd0, 16'h4240);
      xlate("R1 read data seg", 14'h1108, 2'b00, 1'b0, 2'd0, 16'h0108);
   endtask

   task automatic t_bounds;
      xlate("R2 last byte", 14'h06FF, 2'b00, 1'b0, 2'd0, 16'h46FF);
      xlate("R2 offset equals length", 14'h0700, 2'b00, 1'b1, 2'd1, 16'h0000);
      xlate("R2 full-size seg top", 14'h3FFF, 2'b01, 1'b0, 2'd0, 16'h2FFF);
      xlate("R3 empty seg write", 14'h2010, 2'b01, 1'b1, 2'd1, 16'h0000);
      xlate("R3 empty seg fetch", 14'h2000, 2'b10, 1'b1, 2'd1, 16'h0000);
   endtask

   task automatic t_perm;
      xlate("R5 write to read-only traps", 14'h0240, 2'b01, 1'b1, 2'd2, 16'h0000);
      xlate("R5 read same address ok", 14'h0240, 2'b00, 1'b0, 2'd0, 16'h4240);
      xlate("R4 fetch without fetch bit", 14'h1108, 2'b10, 1'b1, 2'd2, 16'h0000);
      xlate("R4 write with write bit", 14'h1108, 2'b01, 1'b0, 2'd0, 16'h0108);
      xlate("R7 reserved access code", 14'h1108, 2'b11, 1'b1, 2'd2, 16'h0000);
   endtask

   task automatic t_priority;
      xlate("R6 bounds over permission", 14'h0800, 2'b01, 1'b1, 2'd1, 16'h0000);
   endtask

   task automatic t_wrap;
      load(2'd3, 16'hFF00, 13'h1000, 3'b011);
      xlate("R1 sum wraps", 14'h3200, 2'b00, 1'b0, 2'd0, 16'h0100);
   endtask

   task automatic t_same_edge;
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 2'd1; cfg_base = 16'h0000; cfg_len = 13'h0000; cfg_perm = 3'b011;
      req_valid = 1'b1; req_vaddr = 14'h1108; req_acc = 2'b00;
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
      chk("R9 same-edge request uses old entry", 1'b1, 1'b0, 2'd0, 16'h0108);
      xlate("R9 later request sees new entry", 14'h1108, 2'b00, 1'b1, 2'd1, 16'h0000);
   endtask

   task automatic t_stream;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = 14'h0010; req_acc = 2'b10;
      @(negedge clk);
      chk("R8 first of back-to-back", 1'b1, 1'b0, 2'd0, 16'h4010);
      req_vaddr = 14'h3001; req_acc = 2'b00;
      @(negedge clk);
      chk("R8 second of back-to-back", 1'b1, 1'b0, 2'd0, 16'hFF01);
      req_valid = 1'b0;
      @(negedge clk);
      chk("R8 R11 idle clears outputs", 1'b0, 1'b0, 2'd0, 16'h0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_setup;
      t_basic;
      t_bounds;
      t_perm;
      t_priority;
      t_wrap;
      t_same_edge;
      t_stream;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog R8: got no completion, expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule